// File: doc/BRIEF.md
# Scatter-Gather Descriptor Sequencer

This block drives a storage host controller's data path from a list of descriptors held in system memory. Software loads a table pointer, programs the block count and block length, and sets a start bit. The engine then fetches each 64-bit descriptor, moves its pointer along the table (or jumps on a link), and hands each transfer entry to a block-transfer unit through a request/done handshake. It keeps a running total of the bytes described and, when the last descriptor has been handled, checks that total against the programmed block geometry.

When an error is raised, the engine halts. It records the state it was in, so software can work out which pointer names the faulty descriptor. A fault during fetch is at the current pointer. A fault during transfer or during the final length check is at the previous pointer. A descriptor can carry an interrupt attribute that pauses the engine until software writes a continue bit. A final-block flag tells a true end of list apart from a halt at a block gap.

Top module: `sg_desc_engine`

## Requirements
- R1: After reset every register reads zero, no memory or transfer request is active and the engine is idle.
- R2: Descriptor layout: bit 0 valid, bit 1 end, bit 2 interrupt, bits [4:3] action (0 nop, 1 reserved, 2 transfer, 3 link), bits [31:16] byte length, bits [63:32] address. In the fetch state the engine requests memory at the current pointer and holds that address until acknowledged.
- R3: A transfer descriptor raises `xfer_req_o` with its address and length, held until `xfer_done_i`. Nop and reserved entries move on without a transfer. A non-link entry advances the pointer by 8. A link entry loads its address into the pointer.
- R4: Each time the pointer advances, the previous-pointer register (address 2) takes the old pointer value.
- R5: A fetched descriptor with valid = 0 raises an error with state code 1 (fetch), and the pointer (address 1) still names it.
- R6: `xfer_done_i` with `xfer_err_i` raises an error with state code 3 (transfer), and the previous pointer names the descriptor.
- R7: After an end descriptor, with block-count enable (control bit 1) set, a byte total other than count × length (address 3: count [15:0], length [27:16]) sets the length-mismatch bit (status bit 2) with error state code 0 (idle).
- R8: A byte total that is not a multiple of the block length, or a block length of zero, also sets the length-mismatch bit.
- R9: Every error gives a one-cycle `err_irq_o` pulse and halts the engine idle. Status bits [1:0] hold the state code and never show 2 (advance). The error flag (status bit 3) and its fields hold until 1 is written to bit 3.
- R10: A descriptor with the interrupt attribute sets status bit 4, which is cleared only by writing 1 to it and is untouched by errors. Without end, the engine pauses (status bit 7).
- R11: Writing 1 to status bit 5 while paused resumes at the next descriptor. Written while not paused, it has no effect.
- R12: A clean finish after an end descriptor pulses `xfer_cmpl_o` and sets the final-block flag (status bit 6). A halt at a block gap (`stop_gap_i` high after a descriptor) pulses `xfer_cmpl_o` with the flag low. Start clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index (0 control, 1 pointer, 2 previous pointer, 3 block geometry, 4 status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | AW | Descriptor address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | AW+32 | Descriptor data |
| xfer_req_o | output | 1 | Transfer request to block-transfer unit |
| xfer_addr_o | output | AW | Transfer buffer address |
| xfer_len_o | output | 16 | Transfer byte length |
| xfer_done_i | input | 1 | Transfer finished |
| xfer_err_i | input | 1 | Transfer failed, valid with xfer_done_i |
| stop_gap_i | input | 1 | Halt request at the next block gap |
| xfer_cmpl_o | output | 1 | Transfer-complete pulse |
| err_irq_o | output | 1 | Error pulse |
| irq_o | output | 1 | Descriptor interrupt status |

## Verification
The bench builds the block with its default widths: 32-bit addresses, a 16-bit block count and a 12-bit block length. These let it use 512-byte and 200-byte blocks and a zero length, and drive the total-length check through its equal, short, non-multiple and count-disabled cases. Descriptor tables sit in a 32-entry memory model, so nops, links, invalid entries and pointer recovery can all be reached on short tables.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FETCH = 2'b01,
    ST_ADV   = 2'b10,
    ST_MOVE  = 2'b11
  } sg_state_e;

  localparam logic [1:0] ACT_NOP  = 2'd0;
  localparam logic [1:0] ACT_RSV  = 2'd1;
  localparam logic [1:0] ACT_XFER = 2'd2;
  localparam logic [1:0] ACT_LINK = 2'd3;

  localparam int B_VALID  = 0;
  localparam int B_END    = 1;
  localparam int B_INT    = 2;
  localparam int B_ACT    = 3;
  localparam int B_LEN    = 16;
  localparam int DLEN_W   = 16;
  localparam int B_ADDR   = 32;
  localparam int STRIDE   = 8;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PTR  = 3'd1;
  localparam logic [2:0] A_PREV = 3'd2;
  localparam logic [2:0] A_BLK  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
endpackage

// File: rtl/sg_len_check.sv
module sg_len_check #(
  parameter int TW  = 32,
  parameter int BCW = 16,
  parameter int BLW = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  add_i,
  input  logic [sg_pkg::DLEN_W-1:0] len_i,
  input  logic                  cnt_en_i,
  input  logic [BCW-1:0]        blk_cnt_i,
  input  logic [BLW-1:0]        blk_len_i,
  output logic                  bad_o
);
  logic [TW-1:0] total_q;
  logic [TW-1:0] blen_w, expect_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    total_q <= '0;
    else if (clr_i) total_q <= '0;
    else if (add_i) total_q <= total_q + TW'(len_i);
  end

  assign blen_w   = TW'(blk_len_i);
  assign expect_w = TW'(blk_cnt_i) * blen_w;

  always_comb begin
    if (blen_w == '0) bad_o = 1'b1;
    else bad_o = ((total_q % blen_w) != '0) || (cnt_en_i && (total_q != expect_w));
  end

  // R8: a zero block length can never pass
  a_r8_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_len_i == '0) |-> bad_o);
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm import sg_pkg::*; #(
  parameter int AW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            cont_i,
  input  logic            ptr_we_i,
  input  logic [AW-1:0]   ptr_wdata_i,
  input  logic            mem_ack_i,
  input  logic [AW+31:0]  mem_rdata_i,
  input  logic            xfer_done_i,
  input  logic            xfer_err_i,
  input  logic            stop_gap_i,
  input  logic            len_bad_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            xfer_req_o,
  output logic [AW-1:0]   xfer_addr_o,
  output logic [DLEN_W-1:0] xfer_len_o,
  output logic [AW-1:0]   sys_ptr_o,
  output logic [AW-1:0]   prev_ptr_o,
  output logic            paused_o,
  output logic            acc_clr_o,
  output logic            acc_add_o,
  output logic            ev_err_o,
  output sg_state_e       ev_err_st_o,
  output logic            ev_lenmis_o,
  output logic            ev_irq_o,
  output logic            ev_cmpl_o,
  output logic            ev_final_o
);
  localparam int DW = AW + 32;

  sg_state_e      st_q, st_d;
  logic [AW-1:0]  sys_q, prev_q;
  logic [DW-1:0]  desc_q;
  logic           paused_q, chk_q;
  logic           d_end, d_int, desc_done;
  logic [1:0]     d_act;

  assign d_end = desc_q[B_END];
  assign d_int = desc_q[B_INT];
  assign d_act = desc_q[B_ACT +: 2];

  assign desc_done = ((st_q == ST_ADV) && (d_act != ACT_XFER)) ||
                     ((st_q == ST_MOVE) && xfer_done_i && !xfer_err_i);

  always_comb begin
    st_d        = st_q;
    acc_clr_o   = 1'b0;
    acc_add_o   = 1'b0;
    ev_err_o    = 1'b0;
    ev_lenmis_o = 1'b0;
    ev_irq_o    = 1'b0;
    ev_cmpl_o   = 1'b0;
    ev_final_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (chk_q) begin
          if (len_bad_i) begin
            ev_err_o    = 1'b1;
            ev_lenmis_o = 1'b1;
          end else begin
            ev_cmpl_o  = 1'b1;
            ev_final_o = 1'b1;
          end
        end else if (start_i && !paused_q) begin
          st_d      = ST_FETCH;
          acc_clr_o = 1'b1;
        end else if (cont_i && paused_q) begin
          st_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_ack_i) begin
          if (!mem_rdata_i[B_VALID]) begin
            ev_err_o = 1'b1;
            st_d     = ST_IDLE;
          end else begin
            st_d = ST_ADV;
          end
        end
      end
      ST_ADV:  if (d_act == ACT_XFER) st_d = ST_MOVE;
      ST_MOVE: begin
        if (xfer_done_i && xfer_err_i) begin
          ev_err_o = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (desc_done) begin
      ev_irq_o  = d_int;
      acc_add_o = (st_q == ST_MOVE);
      if (d_end || d_int) begin
        st_d = ST_IDLE;
      end else if (stop_gap_i) begin
        st_d      = ST_IDLE;
        ev_cmpl_o = 1'b1;
      end else begin
        st_d = ST_FETCH;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      sys_q    <= '0;
      prev_q   <= '0;
      desc_q   <= '0;
      paused_q <= 1'b0;
      chk_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_FETCH && mem_ack_i) desc_q <= mem_rdata_i;
      if (st_q == ST_ADV) begin
        prev_q <= sys_q;
        sys_q  <= (d_act == ACT_LINK) ? desc_q[B_ADDR +: AW] : sys_q + AW'(STRIDE);
      end else if (st_q == ST_IDLE && ptr_we_i) begin
        sys_q <= ptr_wdata_i;
      end
      if (st_q == ST_IDLE)             chk_q <= 1'b0;
      else if (desc_done && d_end)     chk_q <= 1'b1;
      if (st_q == ST_IDLE && cont_i && paused_q && !chk_q) paused_q <= 1'b0;
      else if (desc_done && !d_end && d_int)               paused_q <= 1'b1;
    end
  end

  assign ev_err_st_o = st_q;
  assign mem_req_o   = (st_q == ST_FETCH);
  assign mem_addr_o  = sys_q;
  assign xfer_req_o  = (st_q == ST_MOVE);
  assign xfer_addr_o = desc_q[B_ADDR +: AW];
  assign xfer_len_o  = desc_q[B_LEN +: DLEN_W];
  assign sys_ptr_o   = sys_q;
  assign prev_ptr_o  = prev_q;
  assign paused_o    = paused_q;

  // R2: fetch address held until acknowledged
  a_r2_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R3: transfer request held with its address until done
  a_r3_xfer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i) |=> (xfer_req_o && $stable(xfer_addr_o)));
  // R4: previous pointer takes the old pointer on advance
  a_r4_prev_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADV) |=> (prev_q == $past(sys_q)));
  // R9: an error halts the engine
  a_r9_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_err_o |=> (st_q == ST_IDLE && !mem_req_o && !xfer_req_o));
endmodule

// File: rtl/sg_regs.sv
module sg_regs import sg_pkg::*; #(
  parameter int AW  = 32,
  parameter int BCW = 16,
  parameter int BLW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic [AW-1:0]   sys_ptr_i,
  input  logic [AW-1:0]   prev_ptr_i,
  input  logic            paused_i,
  input  logic            run_start_i,
  input  logic            ev_err_i,
  input  sg_state_e       ev_err_st_i,
  input  logic            ev_lenmis_i,
  input  logic            ev_irq_i,
  input  logic            ev_cmpl_i,
  input  logic            ev_final_i,
  output logic            start_o,
  output logic            cont_o,
  output logic            ptr_we_o,
  output logic [AW-1:0]   ptr_wdata_o,
  output logic            cnt_en_o,
  output logic [BCW-1:0]  blk_cnt_o,
  output logic [BLW-1:0]  blk_len_o,
  output logic            irq_o
);
  localparam int BLEN_LSB = 16;

  logic      err_q, lenmis_q, irq_q, final_q, cnt_en_q;
  sg_state_e err_st_q;
  logic [BCW-1:0] blk_cnt_q;
  logic [BLW-1:0] blk_len_q;
  logic wr_ctrl, wr_stat, wr_blk, irq_clr, err_clr;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_blk  = we_i && (addr_i == A_BLK);
  assign irq_clr = wr_stat && wdata_i[4];
  assign err_clr = wr_stat && wdata_i[3];

  assign start_o     = wr_ctrl && wdata_i[0];
  assign cont_o      = wr_stat && wdata_i[5];
  assign ptr_we_o    = we_i && (addr_i == A_PTR);
  assign ptr_wdata_o = wdata_i[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= 1'b0;
      err_st_q  <= ST_IDLE;
      lenmis_q  <= 1'b0;
      irq_q     <= 1'b0;
      final_q   <= 1'b0;
      cnt_en_q  <= 1'b0;
      blk_cnt_q <= '0;
      blk_len_q <= '0;
    end else begin
      if (wr_ctrl) cnt_en_q <= wdata_i[1];
      if (wr_blk) begin
        blk_cnt_q <= wdata_i[BCW-1:0];
        blk_len_q <= wdata_i[BLEN_LSB +: BLW];
      end
      if (ev_irq_i)     irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (ev_err_i) begin
        err_q    <= 1'b1;
        err_st_q <= ev_err_st_i;
        lenmis_q <= ev_lenmis_i;
      end else if (err_clr) begin
        err_q    <= 1'b0;
        err_st_q <= ST_IDLE;
        lenmis_q <= 1'b0;
      end
      if (run_start_i)    final_q <= 1'b0;
      else if (ev_cmpl_i) final_q <= ev_final_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[1] = cnt_en_q;
      A_PTR:  rdata_o = 32'(sys_ptr_i);
      A_PREV: rdata_o = 32'(prev_ptr_i);
      A_BLK: begin
        rdata_o[BCW-1:0]          = blk_cnt_q;
        rdata_o[BLEN_LSB +: BLW]  = blk_len_q;
      end
      A_STAT: begin
        rdata_o[1:0] = err_st_q;
        rdata_o[2]   = lenmis_q;
        rdata_o[3]   = err_q;
        rdata_o[4]   = irq_q;
        rdata_o[6]   = final_q;
        rdata_o[7]   = paused_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign cnt_en_o  = cnt_en_q;
  assign blk_cnt_o = blk_cnt_q;
  assign blk_len_o = blk_len_q;
  assign irq_o     = irq_q;

  // R9: advance code never reported; error flag sticky
  a_r9_no_adv_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (err_st_q != ST_ADV));
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr) |=> err_q);
  // R10: interrupt status survives everything but its own clear
  a_r10_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr) |=> irq_q);
endmodule

// File: rtl/sg_desc_engine.sv
module sg_desc_engine import sg_pkg::*; #(
  parameter int AW  = 32,
  parameter int BCW = 16,
  parameter int BLW = 12,
  parameter int TW  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_ack_i,
  input  logic [AW+31:0]  mem_rdata_i,
  output logic            xfer_req_o,
  output logic [AW-1:0]   xfer_addr_o,
  output logic [15:0]     xfer_len_o,
  input  logic            xfer_done_i,
  input  logic            xfer_err_i,
  input  logic            stop_gap_i,
  output logic            xfer_cmpl_o,
  output logic            err_irq_o,
  output logic            irq_o
);
  logic start_w, cont_w, ptr_we_w, cnt_en_w, paused_w, len_bad_w;
  logic acc_clr_w, acc_add_w, ev_err_w, ev_lenmis_w, ev_irq_w, ev_cmpl_w, ev_final_w;
  logic [AW-1:0] ptr_wdata_w, sys_ptr_w, prev_ptr_w;
  logic [BCW-1:0] blk_cnt_w;
  logic [BLW-1:0] blk_len_w;
  sg_state_e ev_err_st_w;

  sg_regs #(.AW(AW), .BCW(BCW), .BLW(BLW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .sys_ptr_i(sys_ptr_w), .prev_ptr_i(prev_ptr_w), .paused_i(paused_w),
    .run_start_i(acc_clr_w), .ev_err_i(ev_err_w), .ev_err_st_i(ev_err_st_w),
    .ev_lenmis_i(ev_lenmis_w), .ev_irq_i(ev_irq_w), .ev_cmpl_i(ev_cmpl_w),
    .ev_final_i(ev_final_w), .start_o(start_w), .cont_o(cont_w), .ptr_we_o(ptr_we_w),
    .ptr_wdata_o(ptr_wdata_w), .cnt_en_o(cnt_en_w), .blk_cnt_o(blk_cnt_w),
    .blk_len_o(blk_len_w), .irq_o(irq_o)
  );

  sg_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni,
    .start_i(start_w), .cont_i(cont_w), .ptr_we_i(ptr_we_w), .ptr_wdata_i(ptr_wdata_w),
    .mem_ack_i, .mem_rdata_i, .xfer_done_i, .xfer_err_i, .stop_gap_i,
    .len_bad_i(len_bad_w), .mem_req_o, .mem_addr_o, .xfer_req_o, .xfer_addr_o,
    .xfer_len_o, .sys_ptr_o(sys_ptr_w), .prev_ptr_o(prev_ptr_w), .paused_o(paused_w),
    .acc_clr_o(acc_clr_w), .acc_add_o(acc_add_w), .ev_err_o(ev_err_w),
    .ev_err_st_o(ev_err_st_w), .ev_lenmis_o(ev_lenmis_w), .ev_irq_o(ev_irq_w),
    .ev_cmpl_o(ev_cmpl_w), .ev_final_o(ev_final_w)
  );

  sg_len_check #(.TW(TW), .BCW(BCW), .BLW(BLW)) u_len (
    .clk_i, .rst_ni,
    .clr_i(acc_clr_w), .add_i(acc_add_w), .len_i(xfer_len_o),
    .cnt_en_i(cnt_en_w), .blk_cnt_i(blk_cnt_w), .blk_len_i(blk_len_w), .bad_o(len_bad_w)
  );

  assign xfer_cmpl_o = ev_cmpl_w;
  assign err_irq_o   = ev_err_w;

  // R1: no request leaves the block without its state
  a_r1_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && xfer_req_o));
endmodule

// File: tb/tb_sg_desc_engine.sv
module tb_sg_desc_engine;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_ack = 0;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata = 0;
  logic        xfer_req, xfer_done = 0, xfer_err = 0, stop_gap = 0;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_len;
  logic        xfer_cmpl, err_irq, irq;

  sg_desc_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .xfer_req_o(xfer_req), .xfer_addr_o(xfer_addr), .xfer_len_o(xfer_len),
    .xfer_done_i(xfer_done), .xfer_err_i(xfer_err), .stop_gap_i(stop_gap),
    .xfer_cmpl_o(xfer_cmpl), .err_irq_o(err_irq), .irq_o(irq)
  );

  logic [63:0] mem [32];
  logic        inj_err = 0;
  logic [1:0]  xcnt = 0;
  logic [31:0] last_addr = 0;
  logic [15:0] last_len = 0;
  int n_chk = 0, n_bad = 0, n_cmpl = 0, n_err = 0, n_fetch = 0;

  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[7:3]];
    if (xfer_done) begin
      xfer_done <= 0; xfer_err <= 0; xcnt <= 0;
      last_addr <= xfer_addr; last_len <= xfer_len;
    end else if (xfer_req) begin
      if (xcnt == 2) begin xfer_done <= 1; xfer_err <= inj_err; end
      else xcnt <= xcnt + 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (xfer_cmpl) n_cmpl++;
    if (err_irq)   n_err++;
    if (mem_req)   n_fetch++;
  end

  function automatic logic [63:0] mk(bit v, bit e, bit i, logic [1:0] act,
                                     logic [15:0] len, logic [31:0] a);
    return {a, len, 11'b0, act, i, e, v};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 32; k++) mem[k] = 64'h0;
  endtask

  typedef struct packed {
    logic        en;
    logic [15:0] cnt;
    logic [11:0] blen;
    logic [15:0] la;
    logic [15:0] lb;
    logic        bad;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 16'd4, 12'd512, 16'd1024, 16'd1024, 1'b0},
    '{1'b1, 16'd3, 12'd512, 16'd1024, 16'd1024, 1'b1},
    '{1'b0, 16'd9, 12'd512, 16'd512,  16'd1024, 1'b0},
    '{1'b0, 16'd0, 12'd512, 16'd100,  16'd412,  1'b0},
    '{1'b0, 16'd0, 12'd512, 16'd100,  16'd400,  1'b1},
    '{1'b1, 16'd2, 12'd0,   16'd10,   16'd10,   1'b1},
    '{1'b1, 16'd5, 12'd200, 16'd600,  16'd400,  1'b0}
  };

  localparam logic [31:0] BASE = 32'h100;

  initial begin
    logic [31:0] d;
    int c0, e0, f0;
    fork
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 reg reset", d, 0);
    end
    chk(!mem_req && !xfer_req && !irq, "R1 idle outputs", {mem_req, xfer_req, irq}, 0);

    // R7 R8 R12 length check vectors
    foreach (VECS[i]) begin
      clear_mem();
      mem[0] = mk(1, 0, 0, 2'd2, VECS[i].la, 32'h4000);
      mem[1] = mk(1, 1, 0, 2'd2, VECS[i].lb, 32'h5000);
      wr(4, 32'h8);
      wr(1, BASE);
      wr(3, {4'b0, VECS[i].blen, VECS[i].cnt});
      c0 = n_cmpl; e0 = n_err;
      wr(0, {30'b0, VECS[i].en, 1'b1});
      repeat (60) @(negedge clk);
      rd(4, d);
      chk(d[2] == VECS[i].bad, "R7 R8 length mismatch bit", d[2], VECS[i].bad);
      chk(d[3] == VECS[i].bad, "R9 error flag", d[3], VECS[i].bad);
      chk(d[1:0] == 0, "R7 error state idle", d[1:0], 0);
      chk(d[6] == !VECS[i].bad, "R12 final flag", d[6], !VECS[i].bad);
      chk((n_cmpl - c0) == int'(!VECS[i].bad), "R12 cmpl pulses", n_cmpl - c0, !VECS[i].bad);
      chk((n_err - e0) == int'(VECS[i].bad), "R9 err pulses", n_err - e0, VECS[i].bad);
      rd(2, d);
      chk(d == BASE + 8, "R4 prev at end desc", d, BASE + 8);
    end

    // R3 R4 R5 nop, link, invalid
    clear_mem();
    mem[0] = mk(1, 0, 0, 2'd0, 16'd0, 32'h0);
    mem[1] = mk(1, 0, 0, 2'd3, 16'd0, BASE + 32'h20);
    mem[4] = mk(0, 0, 0, 2'd2, 16'd8, 32'h7000);
    wr(4, 32'h8); wr(1, BASE); wr(3, {4'b0, 12'd512, 16'd1});
    e0 = n_err; c0 = n_cmpl;
    wr(0, 32'h1);
    repeat (40) @(negedge clk);
    rd(4, d);
    chk(d[3] && d[1:0] == 2'd1, "R5 fetch error code", d[3:0], 4'h9);
    rd(1, d);
    chk(d == BASE + 32'h20, "R3 R5 link pointer names bad desc", d, BASE + 32'h20);
    rd(2, d);
    chk(d == BASE + 8, "R4 prev is link desc", d, BASE + 8);
    chk(n_err - e0 == 1 && n_cmpl == c0, "R9 single err pulse", n_err - e0, 1);
    chk(!mem_req && !xfer_req, "R9 halted", {mem_req, xfer_req}, 0);

    // R10 R11 interrupt pause and continue
    clear_mem();
    mem[0] = mk(1, 0, 1, 2'd2, 16'd512, 32'h8000);
    mem[1] = mk(1, 1, 0, 2'd2, 16'd512, 32'h9000);
    wr(4, 32'h8); wr(1, BASE); wr(3, {4'b0, 12'd512, 16'd0});
    c0 = n_cmpl;
    wr(0, 32'h1);
    repeat (40) @(negedge clk);
    rd(4, d);
    chk(d[4] && d[7], "R10 irq set and paused", d[7:4], 4'h9);
    chk(irq, "R10 irq_o", irq, 1);
    chk(n_cmpl == c0, "R10 no completion while paused", n_cmpl - c0, 0);
    rd(1, d);
    chk(d == BASE + 8, "R3 pointer after one desc", d, BASE + 8);
    wr(4, 32'h20);
    repeat (40) @(negedge clk);
    rd(4, d);
    chk(d[6] && !d[7] && d[4], "R11 resumed to final", d[7:4], 4'h5);
    chk(n_cmpl - c0 == 1, "R11 one completion", n_cmpl - c0, 1);
    chk(last_addr == 32'h9000 && last_len == 16'd512, "R3 transfer fields", last_addr, 32'h9000);
    f0 = n_fetch;
    wr(4, 32'h20);
    repeat (20) @(negedge clk);
    rd(1, d);
    chk(d == BASE + 16 && n_fetch == f0, "R11 continue ignored when not paused", d, BASE + 16);

    // R6 R10 transfer error keeps irq status
    clear_mem();
    mem[0] = mk(1, 0, 0, 2'd2, 16'd64, 32'hA000);
    wr(1, BASE);
    inj_err = 1;
    wr(0, 32'h1);
    repeat (40) @(negedge clk);
    inj_err = 0;
    rd(4, d);
    chk(d[3] && d[1:0] == 2'd3, "R6 transfer error code", d[3:0], 4'hB);
    chk(d[4], "R10 irq unaffected by error", d[4], 1);
    rd(2, d);
    chk(d == BASE, "R6 prev names bad desc", d, BASE);
    chk(last_addr == 32'hA000 && last_len == 16'd64, "R3 transfer fields 2", last_len, 64);
    wr(4, 32'h10);
    rd(4, d);
    chk(!d[4] && d[3], "R10 W1C irq leaves error", d[4:3], 2'b01);
    repeat (10) @(negedge clk);
    rd(4, d);
    chk(d[3] && d[1:0] == 2'd3, "R9 error sticky", d[3:0], 4'hB);
    wr(4, 32'h8);
    rd(4, d);
    chk(d[3:0] == 0, "R9 W1C clears error", d[3:0], 0);

    // R12 stop at block gap
    clear_mem();
    mem[0] = mk(1, 0, 0, 2'd2, 16'd512, 32'hB000);
    mem[1] = mk(1, 1, 0, 2'd2, 16'd512, 32'hC000);
    wr(1, BASE);
    stop_gap = 1;
    c0 = n_cmpl;
    wr(0, 32'h1);
    repeat (40) @(negedge clk);
    stop_gap = 0;
    rd(4, d);
    chk(!d[6] && !d[3] && !d[7], "R12 gap halt not final", d[7:0], 0);
    chk(n_cmpl - c0 == 1, "R12 gap completion pulse", n_cmpl - c0, 1);
    rd(1, d);
    chk(d == BASE + 8, "R12 pointer at next desc", d, BASE + 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule